// File: doc/BRIEF.md
# Slice-Addressed Multiport Register File

This block is the architectural register store of a core whose datapath is one byte wide. Each word holds 32 bits, but every access moves one 8-bit slice of a word. A single slice select, shared by all ports, picks which slice is used in a cycle. The core steps that select across the slices to build full-width results over several cycles.

There are two read ports. Each has its own word address, and both are purely combinational. One write port stores one slice per rising edge and leaves the other slices of the word untouched. Word 0 is a constant zero source: writes aimed at it vanish, and reads of it return zero from power-on, with or without a reset. The whole array is also driven out flat on a debug bus, so observers can see every stored bit.

The reset is synchronous and active high. Reads never see a write made in the same cycle: there is no bypass.

Top module: `slice_regfile`

## Requirements
- R1: The array holds 16 words of 32 bits. Slice k of a word is bits [8k+7:8k], so slice select 0 is the least significant byte. The debug bus carries word n on bits [32n+31:32n].
- R2: Each read port returns the slice chosen by the slice select from the word named by that port's own address, in the same cycle, with no clock edge in between.
- R3: With reset high at a rising edge, every word reads zero on the debug bus after that edge.
- R4: The array changes only on a rising edge with write enable high. With enable low, every bit keeps its value.
- R5: A write with enable high stores the write data into the selected slice of the addressed word. The other three slices of that word, and every other word, keep their values.
- R6: A write aimed at address 0 is dropped whatever the enable, and word 0 stays zero on the debug bus.
- R7: A read port given address 0 outputs zero at all times, including before any reset has been applied.
- R8: A read and a write to the same word in the same cycle return the value held before the edge, not the write data.
- R9: The two read ports are independent: different addresses in the same cycle each return their own word's slice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high, clears every word |
| slice_sel | input | 2 | Byte slice used by all ports this cycle |
| rd_addr | input | 8 | Read addresses, port p on bits [4p+3:4p] |
| rd_data | output | 16 | Read data, port p on bits [8p+7:8p] |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 4 | Word addressed by the write |
| wr_data | input | 8 | Slice value to store |
| dbg_words | output | 512 | Full array contents, word n on bits [32n+31:32n] |

## Verification
A corrupted slice stays hidden until a read port addresses that word with the matching slice select. At that point it shows on read data in the same cycle, because the read path has no register. The debug bus shows a bad slice one edge after the faulty write. A fault that lets a write reach the wrong slice or word, or a stray bypass, shows up at once as a mismatch against a reference array model. The bench compares that model on both read ports and on the debug bus in every cycle. Word 0 is checked before the first reset, so a zero that depends on stored state rather than logic is caught.

// File: rtl/slice_rf_pkg.sv
package slice_rf_pkg;

    localparam int DEF_WORD_W   = 32;
    localparam int DEF_SLICE_W  = 8;
    localparam int DEF_ADDR_W   = 4;
    localparam int DEF_RD_PORTS = 2;

    // Width of a select able to name n items (at least one bit).
    function automatic int sel_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/srf_wr_decode.sv
module srf_wr_decode #(
    parameter int NUM_WORDS  = 16,
    parameter int ADDR_W     = 4,
    parameter int NUM_SLICES = 4,
    parameter int SEL_W      = 2
) (
    input  logic                                  wr_en,
    input  logic [ADDR_W-1:0]                     wr_addr,
    input  logic [SEL_W-1:0]                      slice_sel,
    output logic [NUM_WORDS-1:0][NUM_SLICES-1:0]  slice_we
);

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
            if (w == 0) begin : g_zero
                // word 0 is never written
                assign slice_we[w][s] = 1'b0;
            end else begin : g_dec
                assign slice_we[w][s] = wr_en
                                     && (wr_addr == ADDR_W'(w))
                                     && (slice_sel == SEL_W'(s));
            end
        end
    end

endmodule

// File: rtl/srf_word.sv
module srf_word #(
    parameter int SLICE_W    = 8,
    parameter int NUM_SLICES = 4
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic [NUM_SLICES-1:0]                slice_we,
    input  logic [SLICE_W-1:0]                   wr_data,
    output logic [NUM_SLICES-1:0][SLICE_W-1:0]   word_q
);

    for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
        always_ff @(posedge clk) begin
            if (rst) begin
                word_q[s] <= '0;
            end else if (slice_we[s]) begin
                word_q[s] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/srf_read_port.sv
module srf_read_port #(
    parameter int NUM_WORDS  = 16,
    parameter int WORD_W     = 32,
    parameter int SLICE_W    = 8,
    parameter int ADDR_W     = 4,
    parameter int SEL_W      = 2
) (
    input  logic [NUM_WORDS-1:0][WORD_W-1:0] words,
    input  logic [ADDR_W-1:0]                addr,
    input  logic [SEL_W-1:0]                 slice_sel,
    output logic [SLICE_W-1:0]               data
);

    logic [WORD_W-1:0] picked;

    always_comb begin
        picked = words[addr];
        if (addr == '0) begin
            // forced by logic, independent of stored state
            data = '0;
        end else begin
            data = picked[int'(slice_sel) * SLICE_W +: SLICE_W];
        end
    end

endmodule

// File: rtl/slice_regfile.sv
module slice_regfile
    import slice_rf_pkg::*;
#(
    parameter int WORD_W   = DEF_WORD_W,
    parameter int SLICE_W  = DEF_SLICE_W,
    parameter int ADDR_W   = DEF_ADDR_W,
    parameter int RD_PORTS = DEF_RD_PORTS,
    localparam int NUM_WORDS  = 1 << ADDR_W,
    localparam int NUM_SLICES = WORD_W / SLICE_W,
    localparam int SEL_W      = sel_bits(NUM_SLICES)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [SEL_W-1:0]              slice_sel,
    input  logic [RD_PORTS*ADDR_W-1:0]    rd_addr,
    output logic [RD_PORTS*SLICE_W-1:0]   rd_data,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [SLICE_W-1:0]            wr_data,
    output logic [NUM_WORDS*WORD_W-1:0]   dbg_words
);

    typedef struct packed {
        logic               en;
        logic [ADDR_W-1:0]  addr;
        logic [SEL_W-1:0]   sel;
        logic [SLICE_W-1:0] data;
    } wr_req_t;

    initial begin
        if (WORD_W % SLICE_W != 0) begin
            $display("slice_regfile: WORD_W must be a multiple of SLICE_W");
        end
    end

    wr_req_t                                  wreq;
    logic [NUM_WORDS-1:0][NUM_SLICES-1:0]     slice_we;
    logic [NUM_WORDS-1:0][WORD_W-1:0]         words;

    assign wreq = '{en: wr_en, addr: wr_addr, sel: slice_sel, data: wr_data};

    srf_wr_decode #(
        .NUM_WORDS  (NUM_WORDS),
        .ADDR_W     (ADDR_W),
        .NUM_SLICES (NUM_SLICES),
        .SEL_W      (SEL_W)
    ) u_dec (
        .wr_en      (wreq.en),
        .wr_addr    (wreq.addr),
        .slice_sel  (wreq.sel),
        .slice_we   (slice_we)
    );

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        if (w == 0) begin : g_const
            assign words[w] = '0;
            logic unused_we;
            assign unused_we = |slice_we[w];
        end else begin : g_store
            srf_word #(
                .SLICE_W    (SLICE_W),
                .NUM_SLICES (NUM_SLICES)
            ) u_word (
                .clk        (clk),
                .rst        (rst),
                .slice_we   (slice_we[w]),
                .wr_data    (wreq.data),
                .word_q     (words[w])
            );
        end
    end

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
        srf_read_port #(
            .NUM_WORDS  (NUM_WORDS),
            .WORD_W     (WORD_W),
            .SLICE_W    (SLICE_W),
            .ADDR_W     (ADDR_W),
            .SEL_W      (SEL_W)
        ) u_rp (
            .words      (words),
            .addr       (rd_addr[p*ADDR_W +: ADDR_W]),
            .slice_sel  (slice_sel),
            .data       (rd_data[p*SLICE_W +: SLICE_W])
        );
    end

    assign dbg_words = words;

endmodule

// File: rtl/srf_checker.sv
module srf_checker #(
    parameter int WORD_W   = 32,
    parameter int SLICE_W  = 8,
    parameter int ADDR_W   = 4,
    parameter int RD_PORTS = 2,
    parameter int SEL_W    = 2
) (
    input logic                                   clk,
    input logic                                   rst,
    input logic [SEL_W-1:0]                       slice_sel,
    input logic [RD_PORTS*ADDR_W-1:0]             rd_addr,
    input logic [RD_PORTS*SLICE_W-1:0]            rd_data,
    input logic                                   wr_en,
    input logic [ADDR_W-1:0]                      wr_addr,
    input logic [SLICE_W-1:0]                     wr_data,
    input logic [(1<<ADDR_W)*WORD_W-1:0]          dbg_words
);
    localparam int NW = 1 << ADDR_W;
    localparam int NS = WORD_W / SLICE_W;

    function automatic logic [SLICE_W-1:0] pick(
        input logic [NW*WORD_W-1:0] v,
        input logic [ADDR_W-1:0]    a,
        input logic [SEL_W-1:0]     s);
        return v[int'(a) * WORD_W + int'(s) * SLICE_W +: SLICE_W];
    endfunction

    // R3
    reset_clears_chk: assert property (@(posedge clk) rst |=> dbg_words == '0);

    // R4
    idle_holds_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(dbg_words));

    // R5
    slice_stored_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr != '0) |=>
        pick(dbg_words, $past(wr_addr), $past(slice_sel)) == $past(wr_data));

    // R6
    word0_zero_chk: assert property (@(posedge clk) disable iff (rst)
        dbg_words[WORD_W-1:0] == '0);

    for (genvar w = 1; w < NW; w++) begin : g_w
        // R5
        other_word_chk: assert property (@(posedge clk) disable iff (rst)
            !(wr_en && wr_addr == ADDR_W'(w)) |=>
            $stable(dbg_words[w*WORD_W +: WORD_W]));
        for (genvar s = 0; s < NS; s++) begin : g_s
            // R5
            other_slice_chk: assert property (@(posedge clk) disable iff (rst)
                (wr_en && wr_addr == ADDR_W'(w) && slice_sel != SEL_W'(s)) |=>
                $stable(dbg_words[w*WORD_W + s*SLICE_W +: SLICE_W]));
        end
    end

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_p
        // R7
        rd_zero_chk: assert property (@(posedge clk) disable iff (rst)
            rd_addr[p*ADDR_W +: ADDR_W] == '0 |-> rd_data[p*SLICE_W +: SLICE_W] == '0);
        // R2
        rd_match_chk: assert property (@(posedge clk) disable iff (rst)
            rd_addr[p*ADDR_W +: ADDR_W] != '0 |->
            rd_data[p*SLICE_W +: SLICE_W] ==
            pick(dbg_words, rd_addr[p*ADDR_W +: ADDR_W], slice_sel));
    end

endmodule

bind slice_regfile srf_checker #(
    .WORD_W   (WORD_W),
    .SLICE_W  (SLICE_W),
    .ADDR_W   (ADDR_W),
    .RD_PORTS (RD_PORTS),
    .SEL_W    (SEL_W)
) u_srf_chk (
    .clk       (clk),
    .rst       (rst),
    .slice_sel (slice_sel),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .dbg_words (dbg_words)
);

// File: tb/test_slice_regfile.sv
module test_slice_regfile;

    logic         clk = 1'b0;
    logic         rst;
    logic [1:0]   slice_sel;
    logic [7:0]   rd_addr;
    logic [15:0]  rd_data;
    logic         wr_en;
    logic [3:0]   wr_addr;
    logic [7:0]   wr_data;
    logic [511:0] dbg_words;

    int n_run  = 0;
    int n_fail = 0;
    logic [31:0] mdl [16];
    bit mdl_valid = 1'b0;

    always #5 clk = ~clk;

    slice_regfile i_slice_regfile (
        .clk       (clk),
        .rst       (rst),
        .slice_sel (slice_sel),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .dbg_words (dbg_words)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [3:0] a, input logic [1:0] s);
        logic [31:0] w;
        if (a == 4'd0) return 8'h00;
        w = mdl[a];
        return w[s*8 +: 8];
    endfunction

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    // one clock cycle: drive, check combinational outputs, advance, update model
    task automatic cyc(input logic r, input logic we, input logic [3:0] wa,
                       input logic [7:0] wd, input logic [1:0] sel,
                       input logic [3:0] ra0, input logic [3:0] ra1);
        rst = r; wr_en = we; wr_addr = wa; wr_data = wd; slice_sel = sel;
        rd_addr = {ra1, ra0};
        @(negedge clk);
        for (int p = 0; p < 2; p++) begin
            logic [3:0] a;
            a = (p == 0) ? ra0 : ra1;
            if (a == 4'd0)
                check("R7 read of address 0", {24'd0, rd_data[p*8 +: 8]}, 32'd0);
            else if (mdl_valid && we && a == wa)
                check("R8 no bypass", {24'd0, rd_data[p*8 +: 8]}, {24'd0, exp_read(a, sel)});
            else if (mdl_valid)
                check(p == 0 ? "R2 port0 read" : "R9 port1 read",
                      {24'd0, rd_data[p*8 +: 8]}, {24'd0, exp_read(a, sel)});
        end
        if (mdl_valid)
            for (int w = 0; w < 16; w++)
                check("R5 array contents", dbg_words[w*32 +: 32], mdl[w]);
        @(posedge clk);
        #1;
        if (r) begin
            for (int w = 0; w < 16; w++) mdl[w] = 32'd0;
            mdl_valid = 1'b1;
        end else if (we && wa != 4'd0) begin
            mdl[wa][sel*8 +: 8] = wd;
        end
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int w = 0; w < 16; w++) mdl[w] = 32'd0;
        // R7/R6 before any reset: writes to 0, reads of 0 on both ports
        cyc(0, 1, 4'd0, 8'hEE, 2'd1, 4'd0, 4'd0);
        cyc(0, 1, 4'd0, 8'h5A, 2'd3, 4'd0, 4'd0);
        cyc(0, 0, 4'd0, 8'hFF, 2'd2, 4'd0, 4'd0);
        // reset
        cyc(1, 1, 4'd7, 8'h99, 2'd0, 4'd7, 4'd0);
        cyc(1, 0, 4'd0, 8'h00, 2'd0, 4'd0, 4'd0);
        #1;
        for (int w = 0; w < 16; w++)
            check("R3 word zero after reset", dbg_words[w*32 +: 32], 32'd0);
        // R1 slice placement
        cyc(0, 1, 4'd3, 8'h11, 2'd0, 4'd0, 4'd0);
        cyc(0, 1, 4'd3, 8'h22, 2'd1, 4'd0, 4'd0);
        cyc(0, 1, 4'd3, 8'h33, 2'd2, 4'd0, 4'd0);
        cyc(0, 1, 4'd3, 8'h44, 2'd3, 4'd3, 4'd3);
        check("R1 slice order", dbg_words[3*32 +: 32], 32'h44332211);
        // R4 enable low
        cyc(0, 0, 4'd3, 8'hFF, 2'd1, 4'd3, 4'd0);
        check("R4 enable low holds", dbg_words[3*32 +: 32], 32'h44332211);
        // R6 write to 0 with enable
        cyc(0, 1, 4'd0, 8'hEE, 2'd2, 4'd0, 4'd3);
        check("R6 word 0 unchanged", dbg_words[31:0], 32'd0);
        // R8 same address read/write, R9 different ports
        cyc(0, 1, 4'd3, 8'hAB, 2'd1, 4'd3, 4'd5);
        cyc(0, 0, 4'd0, 8'h00, 2'd1, 4'd3, 4'd5);
        check("R8 write visible next cycle", {24'd0, rd_data[7:0]}, 32'h000000AB);
        // random
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] wa, r0, r1;
            wa = 4'($urandom_range(0, 15));
            r0 = ($urandom_range(0, 3) == 0) ? wa : 4'($urandom_range(0, 15));
            r1 = ($urandom_range(0, 3) == 0) ? wa : 4'($urandom_range(0, 15));
            cyc(($urandom_range(0, 299) == 0), 1'($urandom_range(0, 1)), wa,
                8'($urandom), 2'($urandom_range(0, 3)), r0, r1);
        end
        summary();
    end

endmodule